// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits between decode and register-file read in a two-wide, in-order pipeline whose two execution pipes are not alike. The U pipe runs every kind of instruction. The V pipe runs only the common class. Each cycle the decoder presents two instructions in program order. The older one is in slot A and the younger one is in slot B. For each, the decoder gives the destination index, a write enable, two source indices and a 2-bit pipe class. The block decides whether both instructions go out together, with A on U and B on V, or whether A goes out alone.

When the pair is split, B is captured inside the block. On the next cycle B issues by itself on the U pipe, and the block drops `in_ready` for that one cycle so that the decoder keeps its next pair in place. Both issue slots are registered. The decision made from one cycle's inputs appears at the outputs after the next rising clock edge.

The pipe class is coded as follows:
- `00`: runs on either pipe.
- `01`: needs the U pipe.
- `10`: occupies both pipes.
- `11`: marks a bubble.

Top module: `pair_issue_check`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `u_valid` and `v_valid` and drops any captured instruction. After reset, `in_ready` reads 1.
- R2: When both slots are live, B has class `00`, A's class is not `10`, and there is no dependency, the pair is issued. At the next edge `u_valid` and `v_valid` are both 1, the U fields carry A, the V fields carry B, and `in_ready` stays 1.
- R3: A dependency exists when `a_wen` is 1 and `a_dst` equals `b_src_a` or `b_src_b`. A dependency splits the pair. When `a_wen` is 0, a matching index does not split the pair.
- R4: A live B of class `01` splits the pair.
- R5: A live instruction of class `10` in either slot splits the pair. Class `10` never appears on the V pipe and never appears on U while V is valid.
- R6: On a split, A issues alone at the next edge and `in_ready` is 0 for exactly one cycle. During that cycle the captured B issues alone on U, and the slot inputs are ignored.
- R7: A slot is live only when its valid bit is 1 and its class is not `11`. If A is live and B is not, A issues alone, no instruction is captured, and `in_ready` stays 1.
- R8: If B is live and A is not, B issues alone on the U pipe, with no dependency or class check and no stall.
- R9: If neither slot is live, nothing issues at the next edge.
- R10: `v_valid` is never 1 while `u_valid` is 0.
- R11: The outputs are registered: input changes between edges do not alter `u_valid` or `v_valid` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Slot A (older) holds an instruction |
| a_wen | input | 1 | Slot A writes its destination |
| a_cls | input | 2 | Slot A pipe class |
| a_dst | input | REG_W | Slot A destination index |
| a_src_a | input | REG_W | Slot A first source index |
| a_src_b | input | REG_W | Slot A second source index |
| b_valid | input | 1 | Slot B (younger) holds an instruction |
| b_wen | input | 1 | Slot B writes its destination |
| b_cls | input | 2 | Slot B pipe class |
| b_dst | input | REG_W | Slot B destination index |
| b_src_a | input | REG_W | Slot B first source index |
| b_src_b | input | REG_W | Slot B second source index |
| in_ready | output | 1 | Slots are accepted this cycle; low while a captured instruction drains |
| u_valid | output | 1 | U pipe issues an instruction |
| u_wen | output | 1 | U instruction write enable |
| u_cls | output | 2 | U instruction class |
| u_dst | output | REG_W | U instruction destination |
| u_src_a | output | REG_W | U instruction first source |
| u_src_b | output | REG_W | U instruction second source |
| v_valid | output | 1 | V pipe issues an instruction |
| v_wen | output | 1 | V instruction write enable |
| v_cls | output | 2 | V instruction class |
| v_dst | output | REG_W | V instruction destination |
| v_src_a | output | REG_W | V instruction first source |
| v_src_b | output | REG_W | V instruction second source |

## Verification
The bench aims at four kinds of case.

- **Register match without a write.** Slot B reads the register that A names as its destination, but `a_wen` is 0. A design that ignores the write enable would split such pairs for no reason and lose issue slots.
- **Bubbles in one slot.** A bubble in slot B must not cause a stall. A bubble in slot A must let B go out on U. A design that got either wrong would stall needlessly or drop B.
- **Class `10` in slot A.** A design that checks only B's class would let a both-pipe instruction share its cycle with another.
- **Slot inputs during the drain cycle.** The bench drives new, conflicting instructions while `in_ready` is low. A design that sampled them would issue instructions twice or corrupt the captured one.

// File: rtl/pair_issue_check.sv
module pair_issue_check #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic             a_wen,
  input  logic [1:0]       a_cls,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src_a,
  input  logic [REG_W-1:0] a_src_b,
  input  logic             b_valid,
  input  logic             b_wen,
  input  logic [1:0]       b_cls,
  input  logic [REG_W-1:0] b_dst,
  input  logic [REG_W-1:0] b_src_a,
  input  logic [REG_W-1:0] b_src_b,
  output logic             in_ready,
  output logic             u_valid,
  output logic             u_wen,
  output logic [1:0]       u_cls,
  output logic [REG_W-1:0] u_dst,
  output logic [REG_W-1:0] u_src_a,
  output logic [REG_W-1:0] u_src_b,
  output logic             v_valid,
  output logic             v_wen,
  output logic [1:0]       v_cls,
  output logic [REG_W-1:0] v_dst,
  output logic [REG_W-1:0] v_src_a,
  output logic [REG_W-1:0] v_src_b
);
  localparam logic [1:0] CLS_U_ONLY = 2'b01;
  localparam logic [1:0] CLS_BOTH   = 2'b10;
  localparam logic [1:0] CLS_NONE   = 2'b11;

  logic             hold_q;
  logic             h_wen;
  logic [1:0]       h_cls;
  logic [REG_W-1:0] h_dst, h_sa, h_sb;

  logic             f_live, f_wen;
  logic [1:0]       f_cls;
  logic [REG_W-1:0] f_dst, f_sa, f_sb;
  logic             s_live, raw, conflict, split, pair;

  assign in_ready = ~hold_q;

  assign f_live = hold_q | (a_valid & (a_cls != CLS_NONE));
  assign f_wen  = hold_q ? h_wen : a_wen;
  assign f_cls  = hold_q ? h_cls : a_cls;
  assign f_dst  = hold_q ? h_dst : a_dst;
  assign f_sa   = hold_q ? h_sa  : a_src_a;
  assign f_sb   = hold_q ? h_sb  : a_src_b;

  assign s_live = ~hold_q & b_valid & (b_cls != CLS_NONE);

  assign raw      = f_wen & ((f_dst == b_src_a) | (f_dst == b_src_b));
  assign conflict = raw | (b_cls == CLS_U_ONLY) | (b_cls == CLS_BOTH) | (f_cls == CLS_BOTH);
  assign split    = f_live & s_live & conflict;
  assign pair     = f_live & s_live & ~conflict;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      u_valid <= 1'b0;
      v_valid <= 1'b0;
    end else begin
      hold_q  <= split;
      u_valid <= f_live | s_live;
      v_valid <= pair;
    end
  end

  always_ff @(posedge clk) begin
    if (split) begin
      h_wen <= b_wen;
      h_cls <= b_cls;
      h_dst <= b_dst;
      h_sa  <= b_src_a;
      h_sb  <= b_src_b;
    end
  end

  always_ff @(posedge clk) begin
    if (f_live) begin
      u_wen   <= f_wen;
      u_cls   <= f_cls;
      u_dst   <= f_dst;
      u_src_a <= f_sa;
      u_src_b <= f_sb;
    end else begin
      u_wen   <= b_wen;
      u_cls   <= b_cls;
      u_dst   <= b_dst;
      u_src_a <= b_src_a;
      u_src_b <= b_src_b;
    end
    v_wen   <= b_wen;
    v_cls   <= b_cls;
    v_dst   <= b_dst;
    v_src_a <= b_src_a;
    v_src_b <= b_src_b;
  end
endmodule

module pair_issue_check_sva #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             u_valid,
  input logic             u_wen,
  input logic [1:0]       u_cls,
  input logic [REG_W-1:0] u_dst,
  input logic             v_valid,
  input logic [1:0]       v_cls,
  input logic [REG_W-1:0] v_src_a,
  input logic [REG_W-1:0] v_src_b
);
  AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> u_valid); // R10
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready); // R6
  AST_DRAIN_ALONE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (u_valid && !v_valid)); // R6
  AST_V_COMMON_ONLY: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> (v_cls == 2'b00)); // R4
  AST_NO_BOTH_IN_PAIR: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> (u_cls != 2'b10)); // R5
  AST_PAIR_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> !(u_wen && ((u_dst == v_src_a) || (u_dst == v_src_b)))); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!u_valid && !v_valid)); // R1
endmodule

bind pair_issue_check pair_issue_check_sva #(.REG_W(REG_W)) u_sva (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .u_valid(u_valid), .u_wen(u_wen), .u_cls(u_cls), .u_dst(u_dst),
  .v_valid(v_valid), .v_cls(v_cls), .v_src_a(v_src_a), .v_src_b(v_src_b)
);

// File: tb/pair_issue_check_tb.sv
`timescale 1ns/1ps
module pair_issue_check_tb;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_valid = 0, a_wen = 0, b_valid = 0, b_wen = 0;
  logic [1:0] a_cls = 0, b_cls = 0;
  logic [RW-1:0] a_dst = 0, a_src_a = 0, a_src_b = 0;
  logic [RW-1:0] b_dst = 0, b_src_a = 0, b_src_b = 0;
  logic in_ready, u_valid, u_wen, v_valid, v_wen;
  logic [1:0] u_cls, v_cls;
  logic [RW-1:0] u_dst, u_src_a, u_src_b, v_dst, v_src_a, v_src_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit eh_on = 0;
  logic eh_wen;
  logic [1:0] eh_cls;
  logic [RW-1:0] eh_dst, eh_sa, eh_sb;

  always #2.5 clk = ~clk;

  pair_issue_check #(.REG_W(RW)) u_dut (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_wen(a_wen), .a_cls(a_cls), .a_dst(a_dst), .a_src_a(a_src_a), .a_src_b(a_src_b),
    .b_valid(b_valid), .b_wen(b_wen), .b_cls(b_cls), .b_dst(b_dst), .b_src_a(b_src_a), .b_src_b(b_src_b),
    .in_ready(in_ready),
    .u_valid(u_valid), .u_wen(u_wen), .u_cls(u_cls), .u_dst(u_dst), .u_src_a(u_src_a), .u_src_b(u_src_b),
    .v_valid(v_valid), .v_wen(v_wen), .v_cls(v_cls), .v_dst(v_dst), .v_src_a(v_src_a), .v_src_b(v_src_b)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit av, input bit aw, input logic [1:0] ac, input int ad, input int as1, input int as2,
                       input bit bv, input bit bw, input logic [1:0] bc, input int bd, input int bs1, input int bs2);
    a_valid = av; a_wen = aw; a_cls = ac; a_dst = RW'(ad); a_src_a = RW'(as1); a_src_b = RW'(as2);
    b_valid = bv; b_wen = bw; b_cls = bc; b_dst = RW'(bd); b_src_a = RW'(bs1); b_src_b = RW'(bs2);
  endtask

  // Reference model from the requirements; call after inputs are set, before the edge.
  task automatic step();
    string tag;
    bit eu, ev, nh;
    logic xw; logic [1:0] xc; logic [RW-1:0] xd, xa, xb;
    bit al, bl, match;
    al = a_valid && a_cls != 2'b11;
    bl = b_valid && b_cls != 2'b11;
    match = (a_dst == b_src_a) || (a_dst == b_src_b);
    nh = 0; ev = 0; eu = 0;
    xw = a_wen; xc = a_cls; xd = a_dst; xa = a_src_a; xb = a_src_b;
    if (eh_on) begin
      tag = "R6"; eu = 1;
      xw = eh_wen; xc = eh_cls; xd = eh_dst; xa = eh_sa; xb = eh_sb;
    end else if (al && bl) begin
      eu = 1;
      if (a_wen && match) begin tag = "R3"; nh = 1; end
      else if (b_cls == 2'b01) begin tag = "R4"; nh = 1; end
      else if (a_cls == 2'b10 || b_cls == 2'b10) begin tag = "R5"; nh = 1; end
      else begin ev = 1; tag = match ? "R3" : "R2"; end
    end else if (al) begin
      tag = "R7"; eu = 1;
    end else if (bl) begin
      tag = "R8"; eu = 1;
      xw = b_wen; xc = b_cls; xd = b_dst; xa = b_src_a; xb = b_src_b;
    end else begin
      tag = "R9";
    end
    if (nh) begin
      eh_wen = b_wen; eh_cls = b_cls; eh_dst = b_dst; eh_sa = b_src_a; eh_sb = b_src_b;
    end
    begin
      logic bw_s; logic [1:0] bc_s; logic [RW-1:0] bd_s, ba_s, bb_s;
      bw_s = b_wen; bc_s = b_cls; bd_s = b_dst; ba_s = b_src_a; bb_s = b_src_b;
      @(posedge clk); #1;
      eh_on = nh;
      check(tag, "u_valid", u_valid, eu);
      check(tag, "v_valid", v_valid, ev);
      check(eh_on ? "R6" : tag, "in_ready", in_ready, !nh);
      if (v_valid && !u_valid) check("R10", "v without u", 1, 0);
      if (eu) begin
        check(tag, "u_fields", {u_wen, u_cls, u_dst, u_src_a, u_src_b}, {xw, xc, xd, xa, xb});
      end
      if (ev) begin
        check(tag, "v_fields", {v_wen, v_cls, v_dst, v_src_a, v_src_b}, {bw_s, bc_s, bd_s, ba_s, bb_s});
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "u_valid in reset", u_valid, 0);
    check("R1", "v_valid in reset", v_valid, 0);
    check("R1", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst = 0;

    // R11: inputs change mid-cycle, outputs must wait for the edge
    drive(1,1,2'b00,3,1,2, 1,1,2'b00,4,5,6);
    #1 check("R11", "u_valid before edge", u_valid, 0);
    step();                                   // R2 pair
    @(negedge clk); drive(1,1,2'b00,3,1,2, 1,0,2'b00,4,3,6); step();  // R3 dep on src a
    @(negedge clk); drive(1,1,2'b11,7,7,7, 1,1,2'b10,9,9,9); step();  // R6 inputs ignored
    @(negedge clk); drive(1,0,2'b00,3,1,2, 1,0,2'b00,4,6,3); step();  // R3 no wen
    @(negedge clk); drive(1,1,2'b00,3,1,2, 1,1,2'b01,4,5,6); step();  // R4
    @(negedge clk); drive(0,0,2'b00,0,0,0, 0,0,2'b00,0,0,0); step();  // R6 drain
    @(negedge clk); drive(1,1,2'b10,3,1,2, 1,1,2'b00,4,5,6); step();  // R5 first both
    @(negedge clk); drive(1,1,2'b00,3,1,2, 1,1,2'b00,4,5,6); step();  // R6 drain
    @(negedge clk); drive(1,1,2'b00,3,1,2, 1,1,2'b11,4,3,3); step();  // R7 class bubble
    @(negedge clk); drive(1,1,2'b01,3,1,2, 0,1,2'b00,4,3,3); step();  // R7 invalid
    @(negedge clk); drive(0,1,2'b00,4,1,2, 1,1,2'b10,4,4,4); step();  // R8
    @(negedge clk); drive(1,1,2'b11,4,1,2, 0,1,2'b00,4,4,4); step();  // R9

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      drive(($urandom % 10) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 4, $urandom % 4, $urandom % 4,
            ($urandom % 10) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 4, $urandom % 4, $urandom % 4);
      step();
    end

    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    eh_on = 0;
    check("R1", "u_valid after reset", u_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule